// File: doc/BRIEF.md
# Infrared Remote Pulse-Timing Decoder

This block turns a demodulated, active-low infrared remote signal into an address/command code. It measures every edge it acts on with a tick counter, which runs at the system clock divided by a prescale factor and restarts on each of those edges. From the measured times it first qualifies one or more leader pulses and then classifies the data bits. A parameter selects one of two framings. Framing A uses two leader pulses and 32 bits sent most significant bit first, and it carries inverted copies of the address and command for an integrity check. Framing B uses one leader pulse and 20 bits sent least significant bit first, with no check.

Every timing threshold is worked out at elaboration time from the clock frequency and prescale parameters. The decoder keeps the last good code on its output with a valid flag. It raises a one-cycle error pulse whenever it gives up on a frame that was under way. When the enable is low, the decoder sits idle and shows the no-code value.

Top module: `irpd_decoder`

## Requirements
- R1: After reset the code output is the no-code value 32'hFFFF_FFFF, the valid flag is 0 and the error pulse is 0.
- R2: Time is counted in ticks of CLK_HZ/PRESCALE. The count restarts on every edge the decoder acts on, and the cycle of that edge counts as part of the interval.
- R3: A leader pulse starts on a falling edge. It qualifies only if its low time, measured at the next rising edge, is strictly greater than 3/4 and strictly less than 5/4 of a 2400 us nominal. Otherwise the decoder pulses the error output, returns to idle and leaves the code output unchanged.
- R4: Framing A needs two qualified leader pulses in a row and framing B needs one. Each qualified leader pulse sets the code output to the no-code value and clears the valid flag.
- R5: A data interval is accepted only if it is strictly greater than 3/4 of the shorter nominal bit period and strictly less than 5/4 of the longer one. Any other interval ends the frame with an error pulse.
- R6: An accepted interval greater than the mean of the two nominal periods takes the bit value of the longer nominal, and any other accepted interval takes the value of the shorter one. The nominals are 1800 us for a one and 3600 us for a zero in framing A, and 1800 us for a one and 1200 us for a zero in framing B.
- R7: In framing A, the 32 bits fill a word most significant bit first. Its bytes, from the top down, are address, inverted address, command and inverted command. A valid frame loads {16'h0, address, command} and sets the valid flag.
- R8: In framing A, if either byte pair does not XOR to 8'hFF, the decoder loads the no-code value, clears the valid flag and pulses the error output once.
- R9: In framing B, the first 11 bits received form the command, first bit in command bit 0, and the next 9 bits form the address. The code is address*4096 + command, and the frame is always accepted.
- R10: If no edge is acted on for 200 ms (framing A) or 50 ms (framing B) while a frame is under way, the decoder pulses the error output and returns to idle.
- R11: While the enable is low, the decoder stays idle, the code output is the no-code value and the valid flag is 0. Edges on the line have no effect and cause no error pulse.
- R12: The first data interval runs from the rising edge that ends the last leader pulse to the next falling edge. Every later interval runs between falling edges, and rising edges during the data phase are ignored.
- R13: The error output is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, active low, idle high |
| en | input | 1 | Decoder enable |
| code_o | output | 32 | Decoded code, or 32'hFFFF_FFFF when there is none |
| code_valid_o | output | 1 | High while code_o holds a decoded frame |
| frame_err_o | output | 1 | One-cycle pulse when a frame under way is abandoned |

## Verification
The bench places intervals exactly on each side of every threshold: both leader limits, both edges of the bit window and the mean that splits ones from zeros. A design with an off-by-one in its tick count, or with a non-strict comparison, would then take the wrong branch and show a wrong code or a stray error pulse. A corrupted inverted byte has to yield the no-code value; a design that skipped the check would publish it. A single-leader frame on framing A has to produce exactly three leader rejections, which catches a decoder that starts data after one leader. Other tests cut a frame short and wait out the timeout, and drop the enable in the middle of traffic. A decoder that held stale state would then fail to decode the frame sent right after.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD_LOW,
    ST_LEAD_GAP,
    ST_DATA
  } irpd_state_e;

  typedef struct packed {
    logic        ok;
    logic [31:0] code;
  } irpd_result_t;

  localparam longint LEAD_US = 2400;
  localparam longint ONE_US  = 1800;
  localparam logic [31:0] NO_CODE = 32'hFFFF_FFFF;

  function automatic longint us_to_ticks(longint us, longint clk_hz, longint pre);
    return (us * clk_hz / 64'd1000000) / pre;
  endfunction

  function automatic longint zero_us(bit fb);
    return fb ? 64'd1200 : 64'd3600;
  endfunction

  function automatic longint timeout_us(bit fb);
    return fb ? 64'd50000 : 64'd200000;
  endfunction

  function automatic int n_bits(bit fb);
    return fb ? 20 : 32;
  endfunction

  function automatic int n_leads(bit fb);
    return fb ? 1 : 2;
  endfunction

  // Interpret a completed word for the selected framing.
  function automatic irpd_result_t frame_code(bit fb, logic [31:0] w);
    irpd_result_t r;
    if (!fb) begin
      r.ok   = ((w[31:24] ^ w[23:16]) == 8'hFF) && ((w[15:8] ^ w[7:0]) == 8'hFF);
      r.code = {16'h0000, w[31:24], w[15:8]};
    end else begin
      r.ok   = 1'b1;
      r.code = {11'h000, w[20:12], 1'b0, w[11:1]};
    end
    return r;
  endfunction

endpackage

// File: rtl/irpd_edge_sync.sv
module irpd_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ir_in,
  output logic fall_o,
  output logic rise_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= ir_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall_o = s3 & ~s2;
  assign rise_o = ~s3 & s2;
endmodule

// File: rtl/irpd_ticker.sv
module irpd_ticker #(
  parameter int          PRESCALE = 64,
  parameter int          TW       = 18,
  parameter logic [TW-1:0] LIMIT  = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  output logic [TW-1:0] ticks_o,
  output logic          expired_o
);
  logic [TW-1:0] ticks;

  generate
    if (PRESCALE == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ticks <= '0;
        else if (restart_i)       ticks <= TW'(1);
        else if (ticks != '1)     ticks <= ticks + TW'(1);
      end
    end else begin : g_scaled
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pcnt  <= '0;
          ticks <= '0;
        end else if (restart_i) begin
          pcnt  <= PW'(1);
          ticks <= '0;
        end else if (pcnt == PW'(PRESCALE - 1)) begin
          pcnt <= '0;
          if (ticks != '1) ticks <= ticks + TW'(1);
        end else begin
          pcnt <= pcnt + PW'(1);
        end
      end
    end
  endgenerate

  assign ticks_o   = ticks;
  assign expired_o = (ticks >= LIMIT);
endmodule

// File: rtl/irpd_shifter.sv
module irpd_shifter #(
  parameter bit FRAMING = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        shift_i,
  input  logic        bit_i,
  output logic [31:0] word_nxt_o
);
  logic [31:0] sr;

  generate
    if (FRAMING == 1'b0) begin : g_msb_first
      assign word_nxt_o = {sr[30:0], bit_i};
    end else begin : g_lsb_first
      logic [31:0] shifted;
      always_comb begin
        shifted     = {1'b0, sr[31:1]};
        shifted[20] = shifted[20] | bit_i;
      end
      assign word_nxt_o = shifted;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '0;
    else if (clear_i) sr <= '0;
    else if (shift_i) sr <= word_nxt_o;
  end
endmodule

// File: rtl/irpd_decoder.sv
module irpd_decoder import irpd_pkg::*; #(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned PRESCALE = 64,
  parameter bit          FRAMING  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        en,
  output logic [31:0] code_o,
  output logic        code_valid_o,
  output logic        frame_err_o
);
  localparam longint L_LEAD = us_to_ticks(LEAD_US, CLK_HZ, PRESCALE);
  localparam longint L_ONE  = us_to_ticks(ONE_US, CLK_HZ, PRESCALE);
  localparam longint L_ZERO = us_to_ticks(zero_us(FRAMING), CLK_HZ, PRESCALE);
  localparam longint L_TO   = us_to_ticks(timeout_us(FRAMING), CLK_HZ, PRESCALE);
  localparam longint L_SHORT = (L_ONE < L_ZERO) ? L_ONE : L_ZERO;
  localparam longint L_LONG  = (L_ONE < L_ZERO) ? L_ZERO : L_ONE;
  localparam int     TW = $clog2(L_TO + 1) + 1;
  localparam logic [TW-1:0] LEAD_MIN = TW'(L_LEAD * 3 / 4);
  localparam logic [TW-1:0] LEAD_MAX = TW'(L_LEAD * 5 / 4);
  localparam logic [TW-1:0] BIT_MIN  = TW'(L_SHORT * 3 / 4);
  localparam logic [TW-1:0] BIT_MAX  = TW'(L_LONG * 5 / 4);
  localparam logic [TW-1:0] BIT_MID  = TW'((L_ONE + L_ZERO) / 2);
  localparam logic [TW-1:0] TO_T     = TW'(L_TO);
  localparam bit LONG_IS_ONE = (L_ONE > L_ZERO);
  localparam int NB = n_bits(FRAMING);
  localparam int NL = n_leads(FRAMING);

  irpd_state_e   state;
  logic [1:0]    lead_cnt;
  logic [5:0]    bit_cnt;
  logic          fall, rise, expired;
  logic [TW-1:0] ticks;
  logic [31:0]   word_nxt;
  irpd_result_t  res;

  // Named internal events, also observed by the checker.
  logic st_idle, busy, restart, bit_val;
  logic ev_lead_begin, ev_lead_end, ev_lead_ok, ev_lead_bad;
  logic ev_bit_edge, ev_bit, ev_bit_bad, ev_done, ev_timeout;
  logic ev_check_fail, ev_abort;

  irpd_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .fall_o(fall), .rise_o(rise)
  );

  irpd_ticker #(.PRESCALE(PRESCALE), .TW(TW), .LIMIT(TO_T)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .ticks_o(ticks), .expired_o(expired)
  );

  irpd_shifter #(.FRAMING(FRAMING)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear_i(ev_lead_ok), .shift_i(ev_bit),
    .bit_i(bit_val), .word_nxt_o(word_nxt)
  );

  always_comb begin
    st_idle       = (state == ST_IDLE);
    busy          = en && !st_idle;
    ev_timeout    = busy && expired;
    ev_lead_begin = en && fall && (st_idle || (state == ST_LEAD_GAP && !expired));
    ev_lead_end   = en && rise && (state == ST_LEAD_LOW) && !expired;
    ev_lead_ok    = ev_lead_end && (ticks > LEAD_MIN) && (ticks < LEAD_MAX);
    ev_lead_bad   = ev_lead_end && !ev_lead_ok;
    ev_bit_edge   = en && fall && (state == ST_DATA) && !expired;
    ev_bit        = ev_bit_edge && (ticks > BIT_MIN) && (ticks < BIT_MAX);
    ev_bit_bad    = ev_bit_edge && !ev_bit;
    bit_val       = (ticks > BIT_MID) ? LONG_IS_ONE : !LONG_IS_ONE;
    ev_done       = ev_bit && (bit_cnt == 6'(NB - 1));
    res           = frame_code(FRAMING, word_nxt);
    ev_check_fail = ev_done && !res.ok;
    ev_abort      = ev_timeout || ev_lead_bad || ev_bit_bad;
    restart       = ev_lead_begin || ev_lead_end || ev_bit_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lead_cnt <= '0;
      bit_cnt  <= '0;
    end else if (!en) begin
      state    <= ST_IDLE;
      lead_cnt <= '0;
      bit_cnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          lead_cnt <= '0;
          bit_cnt  <= '0;
          if (ev_lead_begin) state <= ST_LEAD_LOW;
        end
        ST_LEAD_LOW: begin
          if (ev_timeout || ev_lead_bad) begin
            state <= ST_IDLE;
          end else if (ev_lead_ok) begin
            lead_cnt <= lead_cnt + 2'd1;
            state    <= (lead_cnt == 2'(NL - 1)) ? ST_DATA : ST_LEAD_GAP;
          end
        end
        ST_LEAD_GAP: begin
          if (ev_timeout)         state <= ST_IDLE;
          else if (ev_lead_begin) state <= ST_LEAD_LOW;
        end
        ST_DATA: begin
          if (ev_timeout || ev_bit_bad || ev_done) state <= ST_IDLE;
          else if (ev_bit) bit_cnt <= bit_cnt + 6'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o       <= NO_CODE;
      code_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      frame_err_o <= ev_abort || ev_check_fail;
      if (!en || ev_lead_ok) begin
        code_o       <= NO_CODE;
        code_valid_o <= 1'b0;
      end else if (ev_done) begin
        code_o       <= res.ok ? res.code : NO_CODE;
        code_valid_o <= res.ok;
      end
    end
  end
endmodule

// File: rtl/irpd_chk.sv
module irpd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [31:0] code_o,
  input logic        code_valid_o,
  input logic        frame_err_o,
  input logic        st_idle,
  input logic        ev_lead_ok,
  input logic        ev_done,
  input logic        ev_timeout,
  input logic        ev_abort
);
  // R1 / R8: without a valid frame the output holds the no-code value
  a_r8_novalid_nocode: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid_o |-> code_o == 32'hFFFF_FFFF);

  a_r7_valid_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |-> code_o != 32'hFFFF_FFFF);

  a_r4_lead_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lead_ok |=> (!code_valid_o && code_o == 32'hFFFF_FFFF));

  a_r10_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (st_idle && frame_err_o));

  a_r5_abort_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (frame_err_o && st_idle));

  a_r13_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);

  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_idle && !code_valid_o));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> st_idle);
endmodule

bind irpd_decoder irpd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .code_o(code_o), .code_valid_o(code_valid_o),
  .frame_err_o(frame_err_o), .st_idle(st_idle), .ev_lead_ok(ev_lead_ok),
  .ev_done(ev_done), .ev_timeout(ev_timeout), .ev_abort(ev_abort)
);

// File: tb/irpd_decoder_tb.sv
module irpd_decoder_tb_top;
  // Scaled timebase: 0.1 tick per microsecond, one tick per clock.
  localparam int unsigned HZ  = 100_000;
  localparam int unsigned PS  = 1;
  localparam logic [31:0] NOC = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, ir_a = 1'b1, ir_b = 1'b1, en_a = 1'b0, en_b = 1'b0;
  logic [31:0] code_a, code_b;
  logic val_a, val_b, err_a, err_b;

  irpd_decoder #(.CLK_HZ(HZ), .PRESCALE(PS), .FRAMING(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_a), .en(en_a),
    .code_o(code_a), .code_valid_o(val_a), .frame_err_o(err_a));

  irpd_decoder #(.CLK_HZ(HZ), .PRESCALE(PS), .FRAMING(1'b1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_b), .en(en_b),
    .code_o(code_b), .code_valid_o(val_b), .frame_err_o(err_b));

  int total = 0, bad = 0, errs_a = 0, errs_b = 0, run = 0, maxrun = 0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (err_a) errs_a++;
    if (err_b) errs_b++;
    if (err_a || err_b) run++; else run = 0;
    if (run > maxrun) maxrun = run;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % 32'(hi - lo + 1));
  endfunction

  // Safe interval per bit value (ticks), well inside the windows.
  function automatic int ival(input bit fb, input bit b);
    if (fb) return b ? rnd(165, 210) : rnd(100, 135);
    return b ? rnd(150, 240) : rnd(300, 420);
  endfunction

  function automatic logic [31:0] mk_a(input logic [7:0] ad, input logic [7:0] cm);
    return {ad, ~ad, cm, ~cm};
  endfunction

  function automatic logic [31:0] exp_a(input logic [31:0] w);
    if (w[23:16] == ~w[31:24] && w[7:0] == ~w[15:8])
      return 32'(w[31:24]) * 256 + 32'(w[15:8]);
    return NOC;
  endfunction

  function automatic logic [31:0] exp_b(input logic [31:0] w);
    int d;
    d = int'(w[19:0]);
    return 32'((d / 2048) * 4096 + (d % 2048));
  endfunction

  task automatic set_ir(input bit fb, input logic v);
    if (fb) ir_b = v; else ir_a = v;
  endtask

  task automatic lead(input bit fb, input int len);
    set_ir(fb, 1'b0);
    wt(len);
    set_ir(fb, 1'b1);
  endtask

  // R12: first interval measured from the leader's rising edge, then fall to fall.
  task automatic bits(input bit fb, input logic [31:0] w, input int nb,
                      input int fidx, input int flen, input int last);
    int hold;
    hold = 0;
    for (int i = 0; i < nb && i <= last; i++) begin
      bit b;
      int d;
      b = fb ? w[i] : w[31 - i];
      d = (i == fidx) ? flen : ival(fb, b);
      wt(d - hold);
      set_ir(fb, 1'b0);
      wt(40);
      set_ir(fb, 1'b1);
      hold = 40;
    end
  endtask

  task automatic frame_a(input logic [31:0] w, input int l1, input int l2,
                         input int fidx, input int flen, input int last);
    lead(1'b0, l1);
    wt(60);
    lead(1'b0, l2);
    bits(1'b0, w, 32, fidx, flen, last);
    wt(12);
  endtask

  task automatic frame_b(input logic [31:0] w, input int l,
                         input int fidx, input int flen, input int last);
    lead(1'b1, l);
    bits(1'b1, w, 20, fidx, flen, last);
    wt(12);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, prev;
    int e0;
    void'($urandom(32'd4242));
    wt(5);
    chk("R1 reset code A", code_a, NOC);
    chk("R1 reset valid A", 32'(val_a), 0);
    chk("R1 reset err A", 32'(err_a), 0);
    chk("R1 reset code B", code_b, NOC);
    rst_n = 1'b1;
    en_a = 1'b1;
    en_b = 1'b1;
    wt(5);

    // R7 R6 R12: random valid frames, framing A
    for (int k = 0; k < 3; k++) begin
      w = mk_a(8'($urandom), 8'($urandom));
      e0 = errs_a;
      frame_a(w, rnd(200, 280), rnd(200, 280), -1, 0, 99);
      chk("R7 code A", code_a, exp_a(w));
      chk("R7 valid A", 32'(val_a), 1);
      chk("R7 no err A", 32'(errs_a - e0), 0);
    end

    // R8: corrupted inverted command byte
    w = mk_a(8'h5A, 8'h3C) ^ 32'h0000_0001;
    e0 = errs_a;
    frame_a(w, 240, 240, -1, 0, 99);
    chk("R8 code A", code_a, exp_a(w));
    chk("R8 valid A", 32'(val_a), 0);
    chk("R8 err A", 32'(errs_a - e0), 1);

    // R6 R3 R2: boundaries; 270 ticks -> 1, 271 -> 0; leaders 299 and 181 pass
    w = mk_a(8'h80 | 8'($urandom), 8'($urandom));
    frame_a(w, 299, 181, 0, 270, 99);
    chk("R6 mid-270 is one A", code_a, exp_a(w));
    w = mk_a(8'h7F & 8'($urandom), 8'($urandom));
    frame_a(w, 240, 240, 0, 271, 99);
    chk("R6 mid-271 is zero A", code_a, exp_a(w));
    prev = code_a;

    // R3: leader of 300 ticks rejected, code unchanged
    e0 = errs_a;
    lead(1'b0, 300);
    wt(12);
    chk("R3 long leader err A", 32'(errs_a - e0), 1);
    chk("R3 long leader keeps code A", code_a, prev);
    chk("R3 long leader keeps valid A", 32'(val_a), 1);

    // R4: one leader only; three short lows follow, each rejected
    e0 = errs_a;
    lead(1'b0, 240);
    bits(1'b0, w, 32, -1, 0, 2);
    wt(12);
    chk("R4 single leader errs A", 32'(errs_a - e0), 3);
    chk("R4 single leader code A", code_a, NOC);
    chk("R4 single leader valid A", 32'(val_a), 0);

    // R5: interval of exactly 450 ticks aborts
    e0 = errs_a;
    frame_a(mk_a(8'h11, 8'h22), 240, 240, 10, 450, 10);
    chk("R5 upper bound err A", 32'(errs_a - e0), 1);
    chk("R5 upper bound valid A", 32'(val_a), 0);

    // R10: frame stops after five bits
    e0 = errs_a;
    frame_a(mk_a(8'h33, 8'h44), 240, 240, -1, 0, 4);
    wt(19000);
    chk("R10 no early timeout A", 32'(errs_a - e0), 0);
    wt(1200);
    chk("R10 timeout err A", 32'(errs_a - e0), 1);
    w = mk_a(8'hC3, 8'h19);
    frame_a(w, 240, 240, -1, 0, 99);
    chk("R10 recovery code A", code_a, exp_a(w));

    // R9 R6: random frames, framing B
    for (int k = 0; k < 5; k++) begin
      w = $urandom & 32'h000F_FFFF;
      e0 = errs_b;
      frame_b(w, rnd(200, 280), -1, 0, 99);
      chk("R9 code B", code_b, exp_b(w));
      chk("R9 valid B", 32'(val_b), 1);
      chk("R9 no err B", 32'(errs_b - e0), 0);
    end

    // R5 R6 R2: window and midpoint boundaries, framing B
    w = ($urandom & 32'h000F_FFFF) & ~32'h1;
    frame_b(w, 240, 0, 91, 99);
    chk("R5 lower edge 91 B", code_b, exp_b(w));
    w = ($urandom & 32'h000F_FFFF) | 32'h1;
    frame_b(w, 240, 0, 224, 99);
    chk("R5 upper edge 224 B", code_b, exp_b(w));
    w = ($urandom & 32'h000F_FFFF) & ~32'h8;
    frame_b(w, 240, 3, 150, 99);
    chk("R6 mid-150 is zero B", code_b, exp_b(w));
    w = ($urandom & 32'h000F_FFFF) | 32'h8;
    frame_b(w, 240, 3, 151, 99);
    chk("R6 mid-151 is one B", code_b, exp_b(w));

    e0 = errs_b;
    frame_b(w, 240, 5, 90, 5);
    chk("R5 interval 90 err B", 32'(errs_b - e0), 1);
    e0 = errs_b;
    frame_b(w, 240, 2, 225, 2);
    chk("R5 interval 225 err B", 32'(errs_b - e0), 1);
    chk("R5 aborted valid B", 32'(val_b), 0);

    // R3 R4 R10: leader boundaries and timeout, framing B
    w = 32'h000A_5C3E;
    frame_b(w, 240, -1, 0, 99);
    e0 = errs_b;
    lead(1'b1, 180);
    wt(12);
    chk("R3 leader 180 err B", 32'(errs_b - e0), 1);
    chk("R3 leader 180 keeps code B", code_b, exp_b(w));
    lead(1'b1, 181);
    wt(12);
    chk("R4 leader 181 clears code B", code_b, NOC);
    chk("R4 leader 181 no err B", 32'(errs_b - e0), 1);
    wt(5100);
    chk("R10 timeout err B", 32'(errs_b - e0), 2);

    // R11: disable drops code and ignores traffic
    w = 32'h0007_1234;
    frame_b(w, 240, -1, 0, 99);
    en_b = 1'b0;
    wt(5);
    chk("R11 disable clears code B", code_b, NOC);
    chk("R11 disable clears valid B", 32'(val_b), 0);
    e0 = errs_b;
    frame_b(w, 240, -1, 0, 99);
    chk("R11 ignored frame code B", code_b, NOC);
    chk("R11 ignored frame err B", 32'(errs_b - e0), 0);
    en_b = 1'b1;
    wt(5);
    frame_b(w, 240, -1, 0, 99);
    chk("R11 re-enabled code B", code_b, exp_b(w));

    chk("R13 err pulse width", 32'(maxrun), 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule